// File: doc/BRIEF.md
# Microprogrammed Control Sequencer

This block walks through a control program kept in an on-chip program store of byte-wide words. Each instruction is two bytes long: an opcode byte followed by an immediate byte. The sequencer fetches the two bytes into separate instruction registers, one byte per fast tick. It decodes the pair only once both bytes are held, and then executes it. The fast tick is produced internally every `FAST_DIV` clocks. Instructions are paced at half that rate, by every second fast tick, which is called the execute tick.

Three kinds of instruction exist:

- a delay, which holds the program counter still for a counted number of execute ticks;
- a jump, which reloads the program counter with a 10-bit target;
- a strobe, which drives its immediate byte onto the control output for one clock.

A separate reconfiguration watchdog counts execute ticks from a value loaded by a restart pulse. When it runs out, it preempts the program: the counter returns to address zero, any pending wait is abandoned, and a sticky status flag is raised. The flag stays set until a clear pulse arrives.

Top module: `mseq_top`

## Requirements
- R1: A synchronous active-high `rst` sets `rom_addr` to 0, `ctl_strobe` to 0 and `recon_flag` to 0, and also clears both instruction registers and any wait or watchdog count.
- R2: A fast tick occurs every `FAST_DIV` clocks. Each fast tick in the running state fetches one byte and advances the address by one: first the opcode byte, then the immediate byte. Back-to-back strobe instructions therefore produce pulses exactly 2·`FAST_DIV` clocks apart, in program order.
- R3: Opcode byte bits [7:6] select the instruction: 00 delay, 01 jump, 10 strobe, 11 reserved. Bits [1:0] of the opcode byte are the high bits of a jump target. Bits [5:2] are ignored.
- R4: A strobe instruction places its immediate byte on `ctl_strobe` for exactly one clock. `ctl_strobe` is zero at all other times.
- R5: A delay instruction with immediate N > 0 freezes `rom_addr` for N execute ticks. A strobe, then a delay N, then a strobe gives pulses (4+2N)·`FAST_DIV` clocks apart. N = 0 gives no wait.
- R6: The reserved opcode acts as a delay of zero whatever its immediate byte, and emits no strobe. A strobe, then a reserved instruction, then a strobe gives pulses 4·`FAST_DIV` clocks apart.
- R7: A jump loads the address with {opcode[1:0], immediate}. A target at or above `ROM_DEPTH` loads 0. The next fetch reads the target.
- R8: After address `ROM_DEPTH`-1 the next fetch reads address 0.
- R9: A `tmo_restart` pulse loads the watchdog with `tmo_load`. A nonzero load expires after that many execute ticks. A load of zero disarms the watchdog.
- R10: On expiry `rom_addr` becomes 0 on the next clock, any delay in progress is abandoned, and `recon_flag` is set.
- R11: `recon_flag` stays set until `flag_clr`. If expiry and `flag_clr` coincide, the flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rom_addr | output | AW | Program store read address |
| rom_data | input | 8 | Program store byte at `rom_addr`, combinational read |
| ctl_strobe | output | 8 | Decoded control strobe vector, one-clock pulse |
| tmo_restart | input | 1 | Reload the reconfiguration watchdog |
| tmo_load | input | TMO_W | Watchdog reload value in execute ticks |
| flag_clr | input | 1 | Clear the reconfiguration status flag |
| recon_flag | output | 1 | Sticky reconfiguration-expired flag |

## Verification
The delay opcode is swept over a contiguous run of wait counts plus two large ones. The measured strobe spacing must follow the (4+2N) law, which tells a frozen counter apart from one that keeps stepping or that counts on the fast tick. The reserved opcode is swept over several immediate bytes to show that its immediate never stretches the gap or leaks onto the strobe. A run of strobes with distinct values separates correct fetch order and byte pairing from a swapped or skipped fetch. Jump programs that land above 255, above the store depth, and near the wrap point separate correct target assembly from a truncated or unclamped one. Watchdog runs during a long delay, with a zero load, and with a clear pulse check that preemption happens on time and that the flag is sticky.

// File: rtl/mseq_pkg.sv
package mseq_pkg;

    typedef enum logic [1:0] {
        OP_DLY = 2'b00,
        OP_JMP = 2'b01,
        OP_STB = 2'b10,
        OP_RSV = 2'b11
    } op_e;

    typedef struct packed {
        op_e        op;
        logic [3:0] spare;
        logic [1:0] hi;
    } opbyte_t;

    typedef enum logic {
        SQ_RUN  = 1'b0,
        SQ_WAIT = 1'b1
    } sq_state_e;

    localparam int TGT_W = 10;

    function automatic logic [TGT_W-1:0] jump_target(opbyte_t ob, logic [7:0] imm);
        return {ob.hi, imm};
    endfunction

endpackage

// File: rtl/mseq_tick.sv
module mseq_tick #(
    parameter int FAST_DIV = 4,
    localparam int CW = (FAST_DIV > 2) ? $clog2(FAST_DIV) : 1
) (
    input  logic clk,
    input  logic rst,
    output logic fast_tick
);
    logic [CW-1:0] cnt;

    assign fast_tick = (cnt == CW'(FAST_DIV - 1));

    always_ff @(posedge clk) begin
        if (rst)            cnt <= '0;
        else if (fast_tick) cnt <= '0;
        else                cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/mseq_wdog.sv
module mseq_wdog #(
    parameter int TMO_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             exec_tick,
    input  logic             restart,
    input  logic [TMO_W-1:0] load,
    input  logic             flag_clr,
    output logic             expire,
    output logic             flag
);
    logic [TMO_W-1:0] cnt;
    logic             armed;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt    <= '0;
            armed  <= 1'b0;
            expire <= 1'b0;
        end else begin
            expire <= 1'b0;
            if (restart) begin
                cnt   <= load;
                armed <= (load != '0);
            end else if (exec_tick && armed) begin
                if (cnt == TMO_W'(1)) begin
                    expire <= 1'b1;
                    armed  <= 1'b0;
                end
                cnt <= cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)           flag <= 1'b0;
        else if (expire)   flag <= 1'b1;
        else if (flag_clr) flag <= 1'b0;
    end
endmodule

// File: rtl/mseq_core.sv
module mseq_core
    import mseq_pkg::*;
#(
    parameter int ROM_DEPTH = 544,
    localparam int AW = $clog2(ROM_DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          fast_tick,
    input  logic          expire,
    input  logic [7:0]    rom_data,
    output logic [AW-1:0] pc,
    output logic [7:0]    strobe,
    output logic          exec_tick,
    output logic          seq_wait,
    output logic          dec_pend
);
    localparam logic [AW-1:0] LAST = AW'(ROM_DEPTH - 1);

    sq_state_e        state;
    logic             phase;
    logic [7:0]       ir_op;
    logic [7:0]       ir_imm;
    logic [7:0]       dly;
    opbyte_t          ob;
    logic [TGT_W-1:0] tgt;
    logic [AW-1:0]    pc_inc;
    logic [AW-1:0]    pc_jmp;

    assign ob        = opbyte_t'(ir_op);
    assign tgt       = jump_target(ob, ir_imm);
    assign pc_inc    = (pc == LAST) ? '0 : pc + 1'b1;
    assign pc_jmp    = (int'(tgt) >= ROM_DEPTH) ? '0 : AW'(tgt);
    assign exec_tick = fast_tick && phase;
    assign seq_wait  = (state == SQ_WAIT);

    always_ff @(posedge clk) begin
        if (rst) begin
            pc       <= '0;
            phase    <= 1'b0;
            ir_op    <= '0;
            ir_imm   <= '0;
            dly      <= '0;
            state    <= SQ_RUN;
            dec_pend <= 1'b0;
            strobe   <= '0;
        end else if (expire) begin
            pc       <= '0;
            phase    <= 1'b0;
            state    <= SQ_RUN;
            dec_pend <= 1'b0;
            strobe   <= '0;
        end else begin
            strobe   <= '0;
            dec_pend <= 1'b0;
            if (fast_tick) begin
                phase <= ~phase;
                if (state == SQ_RUN) begin
                    pc <= pc_inc;
                    if (!phase) begin
                        ir_op <= rom_data;
                    end else begin
                        ir_imm   <= rom_data;
                        dec_pend <= 1'b1;
                    end
                end else if (phase) begin
                    if (dly == 8'd1) state <= SQ_RUN;
                    dly <= dly - 1'b1;
                end
            end
            if (dec_pend) begin
                unique case (ob.op)
                    OP_JMP: pc     <= pc_jmp;
                    OP_STB: strobe <= ir_imm;
                    OP_DLY: begin
                        if (ir_imm != 8'd0) begin
                            state <= SQ_WAIT;
                            dly   <= ir_imm;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/mseq_top.sv
module mseq_top
    import mseq_pkg::*;
#(
    parameter int ROM_DEPTH = 544,
    parameter int FAST_DIV  = 4,
    parameter int TMO_W     = 16,
    localparam int AW = $clog2(ROM_DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    output logic [AW-1:0]    rom_addr,
    input  logic [7:0]       rom_data,
    output logic [7:0]       ctl_strobe,
    input  logic             tmo_restart,
    input  logic [TMO_W-1:0] tmo_load,
    input  logic             flag_clr,
    output logic             recon_flag
);
    logic fast_tick;
    logic exec_tick;
    logic wd_expire;
    logic seq_wait;
    logic dec_pend;

    mseq_tick #(.FAST_DIV(FAST_DIV)) u_tick (
        .clk       (clk),
        .rst       (rst),
        .fast_tick (fast_tick)
    );

    mseq_core #(.ROM_DEPTH(ROM_DEPTH)) u_core (
        .clk       (clk),
        .rst       (rst),
        .fast_tick (fast_tick),
        .expire    (wd_expire),
        .rom_data  (rom_data),
        .pc        (rom_addr),
        .strobe    (ctl_strobe),
        .exec_tick (exec_tick),
        .seq_wait  (seq_wait),
        .dec_pend  (dec_pend)
    );

    mseq_wdog #(.TMO_W(TMO_W)) u_wdog (
        .clk       (clk),
        .rst       (rst),
        .exec_tick (exec_tick),
        .restart   (tmo_restart),
        .load      (tmo_load),
        .flag_clr  (flag_clr),
        .expire    (wd_expire),
        .flag      (recon_flag)
    );
endmodule

// File: rtl/mseq_chk.sv
module mseq_chk #(
    parameter int ROM_DEPTH = 544,
    localparam int AW = $clog2(ROM_DEPTH)
) (
    input logic          clk,
    input logic          rst,
    input logic [AW-1:0] rom_addr,
    input logic [7:0]    ctl_strobe,
    input logic          recon_flag,
    input logic          flag_clr,
    input logic          fast_tick,
    input logic          seq_wait,
    input logic          dec_pend,
    input logic          wd_expire
);
    AST_STROBE_ONE_CLOCK: assert property (@(posedge clk) disable iff (rst)
        (ctl_strobe != 8'd0) |=> (ctl_strobe == 8'd0)); // R4

    AST_WAIT_ADDR_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (seq_wait && !wd_expire) |=> $stable(rom_addr)); // R5

    AST_ADDR_ONLY_ON_EVENT: assert property (@(posedge clk) disable iff (rst)
        (!fast_tick && !dec_pend && !wd_expire) |=> $stable(rom_addr)); // R2

    AST_EXPIRE_TO_ZERO: assert property (@(posedge clk) disable iff (rst)
        wd_expire |=> (rom_addr == '0) && recon_flag && !seq_wait); // R10

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
        (recon_flag && !flag_clr) |=> recon_flag); // R11

    AST_FLAG_SET_WINS: assert property (@(posedge clk) disable iff (rst)
        (wd_expire && flag_clr) |=> recon_flag); // R11

    AST_FLAG_CAUSE: assert property (@(posedge clk) disable iff (rst)
        $rose(recon_flag) |-> $past(wd_expire)); // R10

    AST_ADDR_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        int'(rom_addr) < ROM_DEPTH); // R8
endmodule

bind mseq_top mseq_chk #(.ROM_DEPTH(ROM_DEPTH)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .rom_addr   (rom_addr),
    .ctl_strobe (ctl_strobe),
    .recon_flag (recon_flag),
    .flag_clr   (flag_clr),
    .fast_tick  (fast_tick),
    .seq_wait   (seq_wait),
    .dec_pend   (dec_pend),
    .wd_expire  (wd_expire)
);

// File: tb/mseq_top_tb.sv
module mseq_top_tb;
    localparam int DEPTH = 544;
    localparam int FD    = 4;
    localparam int TW    = 16;
    localparam int AW    = $clog2(DEPTH);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] rom_addr;
    logic [7:0]    rom_data;
    logic [7:0]    ctl_strobe;
    logic          tmo_restart = 1'b0;
    logic [TW-1:0] tmo_load = '0;
    logic          flag_clr = 1'b0;
    logic          recon_flag;

    logic [7:0] rom [0:DEPTH-1];
    assign rom_data = rom[rom_addr];

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    int ev_n = 0;
    logic [7:0] ev_val [0:1023];
    int         ev_cyc [0:1023];

    always #4 clk = ~clk;

    mseq_top #(.ROM_DEPTH(DEPTH), .FAST_DIV(FD), .TMO_W(TW)) u_dut (
        .clk(clk), .rst(rst), .rom_addr(rom_addr), .rom_data(rom_data),
        .ctl_strobe(ctl_strobe), .tmo_restart(tmo_restart), .tmo_load(tmo_load),
        .flag_clr(flag_clr), .recon_flag(recon_flag)
    );

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (!rst && ctl_strobe != 8'd0 && ev_n < 1024) begin
            ev_val[ev_n] = ctl_strobe;
            ev_cyc[ev_n] = cyc;
            ev_n = ev_n + 1;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic clear_rom();
        for (int i = 0; i < DEPTH; i++) rom[i] = 8'h00;
    endtask

    // opcode byte: [7:6] op, [1:0] jump high bits (R3)
    task automatic put(input int addr, input int op, input int hi, input int imm);
        rom[addr]     = 8'((op << 6) | (hi & 3));
        rom[addr + 1] = 8'(imm);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic wait_ev(input int target, input int lim);
        int t = 0;
        while (ev_n < target && t < lim) begin
            @(negedge clk);
            t++;
        end
    endtask

    task automatic pulse_restart(input int val);
        @(negedge clk);
        tmo_load = TW'(val);
        tmo_restart = 1'b1;
        @(negedge clk);
        tmo_restart = 1'b0;
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog timeout actual=%0d expected=%0d", cyc, 150000);
        summary();
    end

    initial begin
        int b;
        int nv [0:10];

        // R1: reset state
        clear_rom();
        put(0, 2, 0, 8'h11);
        do_reset();
        check(rom_addr == 0, "R1 addr", int'(rom_addr), 0);
        check(ctl_strobe == 0, "R1 strobe", int'(ctl_strobe), 0);
        check(recon_flag == 0, "R1 flag", int'(recon_flag), 0);

        // R2 R4: consecutive strobes in order, 2*FD apart
        clear_rom();
        for (int i = 0; i < 8; i++) put(2 * i, 2, 0, (i * 37 + 1) & 8'hFF);
        put(16, 1, 0, 16);
        b = ev_n;
        do_reset();
        wait_ev(b + 8, 2000);
        repeat (100) @(negedge clk);
        check(ev_n == b + 8, "R4 pulse count", ev_n - b, 8);
        for (int i = 0; i < 8; i++) begin
            check(ev_val[b + i] == 8'((i * 37 + 1) & 8'hFF), "R2 order",
                  int'(ev_val[b + i]), (i * 37 + 1) & 8'hFF);
            if (i > 0)
                check(ev_cyc[b + i] - ev_cyc[b + i - 1] == 2 * FD, "R2 spacing",
                      ev_cyc[b + i] - ev_cyc[b + i - 1], 2 * FD);
        end

        // R5 R3: delay sweep, spacing (4+2N)*FD
        for (int k = 0; k < 11; k++) nv[k] = k;
        nv[9] = 100;
        nv[10] = 255;
        for (int k = 0; k < 11; k++) begin
            clear_rom();
            put(0, 2, 0, 8'h11);
            put(2, 0, 0, nv[k]);
            put(4, 2, 0, 8'h22);
            put(6, 1, 0, 6);
            b = ev_n;
            do_reset();
            wait_ev(b + 2, 5000);
            check(ev_n >= b + 2 && ev_val[b + 1] == 8'h22, "R5 second strobe",
                  int'(ev_val[b + 1]), 8'h22);
            check(ev_cyc[b + 1] - ev_cyc[b] == (4 + 2 * nv[k]) * FD, "R5 delay spacing",
                  ev_cyc[b + 1] - ev_cyc[b], (4 + 2 * nv[k]) * FD);
        end

        // R6: reserved opcode ignores immediate
        for (int k = 0; k < 4; k++) begin
            int imm = (k == 0) ? 0 : (k == 1) ? 1 : (k == 2) ? 8'h80 : 8'hFF;
            clear_rom();
            put(0, 2, 0, 8'h11);
            put(2, 3, 0, imm);
            put(4, 2, 0, 8'h22);
            put(6, 1, 0, 6);
            b = ev_n;
            do_reset();
            wait_ev(b + 2, 2000);
            check(ev_n >= b + 2 && ev_val[b + 1] == 8'h22, "R6 no strobe",
                  int'(ev_val[b + 1]), 8'h22);
            check(ev_cyc[b + 1] - ev_cyc[b] == 4 * FD, "R6 spacing",
                  ev_cyc[b + 1] - ev_cyc[b], 4 * FD);
        end

        // R7: jump above 255 via opcode high bits
        clear_rom();
        put(0, 2, 0, 8'hA1);
        put(2, 1, 2, 8'h10);
        put(4, 2, 0, 8'hEE);
        put(12'h210, 2, 0, 8'hA2);
        put(12'h212, 1, 2, 8'h12);
        b = ev_n;
        do_reset();
        wait_ev(b + 2, 2000);
        check(ev_val[b + 1] == 8'hA2, "R7 target", int'(ev_val[b + 1]), 8'hA2);
        check(ev_cyc[b + 1] - ev_cyc[b] == 4 * FD, "R7 spacing",
              ev_cyc[b + 1] - ev_cyc[b], 4 * FD);

        // R7: target beyond depth goes to 0
        clear_rom();
        put(0, 2, 0, 8'hB1);
        put(2, 1, 3, 8'hFF);
        b = ev_n;
        do_reset();
        wait_ev(b + 3, 2000);
        check(ev_val[b + 2] == 8'hB1, "R7 clamp value", int'(ev_val[b + 2]), 8'hB1);
        check(ev_cyc[b + 2] - ev_cyc[b + 1] == 4 * FD, "R7 clamp spacing",
              ev_cyc[b + 2] - ev_cyc[b + 1], 4 * FD);

        // R8: wrap from last address to 0
        clear_rom();
        put(0, 1, 2, DEPTH - 4 - 512);
        put(DEPTH - 4, 2, 0, 8'hC1);
        put(DEPTH - 2, 2, 0, 8'hC2);
        b = ev_n;
        do_reset();
        wait_ev(b + 3, 2000);
        check(ev_val[b + 1] == 8'hC2 && ev_val[b + 2] == 8'hC1, "R8 wrap order",
              int'(ev_val[b + 2]), 8'hC1);
        check(ev_cyc[b + 2] - ev_cyc[b + 1] == 4 * FD, "R8 wrap spacing",
              ev_cyc[b + 2] - ev_cyc[b + 1], 4 * FD);

        // R9 R10 R11: watchdog during a long delay
        clear_rom();
        put(0, 2, 0, 8'h5A);
        put(2, 0, 0, 255);
        put(4, 1, 0, 2);
        b = ev_n;
        do_reset();
        wait_ev(b + 1, 2000);
        b = ev_n;
        pulse_restart(5);
        begin
            bit early = 0;
            for (int i = 0; i < (2 * 5 - 2) * FD - 1; i++) begin
                @(negedge clk);
                if (recon_flag) early = 1;
            end
            check(!early, "R9 not early", int'(early), 0);
        end
        begin
            int t = 0;
            while (!recon_flag && t < 4 * FD + 4) begin
                @(negedge clk);
                t++;
            end
        end
        check(recon_flag == 1, "R9 expiry", int'(recon_flag), 1);
        check(rom_addr <= 2, "R10 addr reset", int'(rom_addr), 0);
        wait_ev(b + 1, 6 * FD);
        check(ev_n == b + 1 && ev_val[b] == 8'h5A, "R10 restart at 0", ev_n - b, 1);
        repeat (50) @(negedge clk);
        check(recon_flag == 1, "R11 sticky", int'(recon_flag), 1);
        flag_clr = 1'b1;
        @(negedge clk);
        flag_clr = 1'b0;
        check(recon_flag == 0, "R11 clear", int'(recon_flag), 0);

        // R9: zero load disarms
        pulse_restart(0);
        repeat (2000) @(negedge clk);
        check(recon_flag == 0, "R9 disarmed", int'(recon_flag), 0);

        // R1: reset clears a set flag
        pulse_restart(1);
        repeat (4 * FD + 4) @(negedge clk);
        check(recon_flag == 1, "R9 short load", int'(recon_flag), 1);
        do_reset();
        check(recon_flag == 0, "R1 flag after reset", int'(recon_flag), 0);
        check(rom_addr == 0, "R1 addr after reset", int'(rom_addr), 0);

        summary();
    end
endmodule